// File: doc/BRIEF.md
# Narrow Bus to Wide Memory Port Bridge

This block is a Wishbone classic slave that sits between a narrow system bus and a wide native memory port, such as the port of a DRAM controller crossbar. Each bus access becomes exactly one native command. The low bits of the bus word address pick a lane inside the wide native word. The remaining bits form the native command address.

On a write, the bridge places the bus data in the selected lane. It also builds a per-byte enable mask from the bus select, shifted to the same lane. A select of all zeros is treated as a write to every byte of the addressed bus word. On a read, the bridge waits for the native read data and returns the selected lane on the bus, together with a single-cycle acknowledge. The bus data width and the select granularity are parameters. Each select bit covers granularity/8 consecutive byte enables.

Top module: `wbn_bridge`

## Requirements
- R1: While reset is applied and directly after it, `bus_ack`, `mem_cmd_valid` and `mem_wr_valid` are low.
- R2: An access started by `bus_cyc` and `bus_stb` raises `mem_cmd_valid`. `mem_cmd_addr` equals the bus word address with its low log2(NATIVE_DW/BUS_DW) bits removed, and `mem_cmd_we` equals the bus write flag.
- R3: `mem_cmd_valid` stays high, with a stable `mem_cmd_addr`, until the cycle in which `mem_cmd_ready` is high.
- R4: On a write, the bus word appears at bits [lane*BUS_DW +: BUS_DW] of `mem_wr_data`, where lane is the dropped low address bits. All other bits are zero.
- R5: The write byte-enable mask has bit lane*(BUS_DW/8) + g*(GRAN/8) + k set for every select bit g that is 1, with k running from 0 to GRAN/8-1. No other bit is set. With 32-bit data and 16-bit granularity, select 2'b01 at lane 2 gives 16'h0300.
- R6: A write with an all-zero select enables every byte of the addressed lane. With 32-bit data at lane 0 the mask is 16'h000F.
- R7: `mem_wr_valid` rises in the cycle after the command handshake of a write, and it stays high with stable data and mask until `mem_wr_ready`. `bus_ack` is high in the cycle after the write-data handshake.
- R8: On a read, `bus_ack` is high in the cycle after `mem_rd_valid` is seen following the command handshake. At that point `bus_dat_r` holds bits [lane*BUS_DW +: BUS_DW] of the `mem_rd_data` sampled then.
- R9: `bus_ack` is high for exactly one cycle per access. `mem_cmd_valid` and `mem_wr_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write flag |
| bus_adr | input | NATIVE_AW+log2(NATIVE_DW/BUS_DW) | Bus word address |
| bus_sel | input | BUS_DW/GRAN | Bus select |
| bus_dat_w | input | BUS_DW | Bus write data |
| bus_dat_r | output | BUS_DW | Bus read data |
| bus_ack | output | 1 | Bus acknowledge |
| mem_cmd_valid | output | 1 | Native command valid |
| mem_cmd_ready | input | 1 | Native command ready |
| mem_cmd_we | output | 1 | Native command is a write |
| mem_cmd_addr | output | NATIVE_AW | Native word address |
| mem_wr_valid | output | 1 | Write data valid |
| mem_wr_ready | input | 1 | Write data ready |
| mem_wr_data | output | NATIVE_DW | Write data, lane placed |
| mem_wr_be | output | NATIVE_DW/8 | Write byte enables |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | NATIVE_DW | Read data |

## Verification
With the native side always ready, the command is presented one cycle after the bus strobe is sampled. Write data or the read wait follows one cycle after the command handshake, and the acknowledge comes one cycle after the final native handshake. The bench acts as the native side and makes random per-cycle ready and valid decisions at the falling edge. Because of this, it knows at each falling edge which handshake the next rising edge completes. It then requires the acknowledge at precisely the following falling edge and nowhere else. Command fields, lane data and masks are compared at every falling edge while their valid is high. Read data is compared in the acknowledge cycle, and the cycle after that must show the acknowledge low again.

// File: rtl/wbn_pkg.sv
package wbn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_WDATA = 3'd2,
    ST_RWAIT = 3'd3,
    ST_DONE  = 3'd4
  } wbn_state_t;
endpackage

// File: rtl/wbn_lane_pack.sv
module wbn_lane_pack #(
  parameter int BUS_DW    = 32,
  parameter int GRAN      = 8,
  parameter int NATIVE_DW = 128,
  localparam int LANES     = NATIVE_DW / BUS_DW,
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SEL_W     = BUS_DW / GRAN,
  localparam int BPG       = GRAN / 8,
  localparam int LANE_BYTES = BUS_DW / 8,
  localparam int NBYTES    = NATIVE_DW / 8
) (
  input  logic [LANE_BITS-1:0] lane,
  input  logic [SEL_W-1:0]     sel,
  input  logic [BUS_DW-1:0]    dat,
  output logic [NATIVE_DW-1:0] wide_data,
  output logic [NBYTES-1:0]    wide_be
);
  logic [SEL_W-1:0]      sel_eff;
  logic [LANE_BYTES-1:0] word_be;

  // an empty select means the whole bus word
  always_comb begin
    sel_eff = (sel == '0) ? {SEL_W{1'b1}} : sel;
  end

  for (genvar g = 0; g < SEL_W; g++) begin : g_expand
    assign word_be[g*BPG +: BPG] = {BPG{sel_eff[g]}};
  end

  always_comb begin
    wide_data = '0;
    wide_be   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane == LANE_BITS'(l)) begin
        wide_data[l*BUS_DW +: BUS_DW]       = dat;
        wide_be[l*LANE_BYTES +: LANE_BYTES] = word_be;
      end
    end
  end
endmodule

// File: rtl/wbn_lane_pick.sv
module wbn_lane_pick #(
  parameter int BUS_DW    = 32,
  parameter int NATIVE_DW = 128,
  localparam int LANES     = NATIVE_DW / BUS_DW,
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANE_BITS-1:0] lane,
  input  logic [NATIVE_DW-1:0] wide_data,
  output logic [BUS_DW-1:0]    word
);
  always_comb begin
    word = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane == LANE_BITS'(l)) word = wide_data[l*BUS_DW +: BUS_DW];
    end
  end
endmodule

// File: rtl/wbn_ctrl.sv
module wbn_ctrl
  import wbn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic is_write,
  input  logic cmd_ready,
  input  logic wr_ready,
  input  logic rd_valid,
  output logic accept,
  output logic cmd_valid,
  output logic wr_valid,
  output logic rd_take,
  output logic ack
);
  wbn_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req)       st_d = ST_CMD;
      ST_CMD:   if (cmd_ready) st_d = is_write ? ST_WDATA : ST_RWAIT;
      ST_WDATA: if (wr_ready)  st_d = ST_DONE;
      ST_RWAIT: if (rd_valid)  st_d = ST_DONE;
      ST_DONE:                 st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign accept    = (st_q == ST_IDLE) && req;
  assign cmd_valid = (st_q == ST_CMD);
  assign wr_valid  = (st_q == ST_WDATA);
  assign rd_take   = (st_q == ST_RWAIT) && rd_valid;
  assign ack       = (st_q == ST_DONE);

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);
  assert_wr_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> ack);
  assert_rd_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> ack);
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_valid));
endmodule

// File: rtl/wbn_bridge.sv
module wbn_bridge #(
  parameter int BUS_DW    = 32,
  parameter int GRAN      = 8,
  parameter int NATIVE_DW = 128,
  parameter int NATIVE_AW = 3,
  localparam int LANES     = NATIVE_DW / BUS_DW,
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BUS_AW    = NATIVE_AW + LANE_BITS,
  localparam int SEL_W     = BUS_DW / GRAN,
  localparam int NBYTES    = NATIVE_DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cyc,
  input  logic                 bus_stb,
  input  logic                 bus_we,
  input  logic [BUS_AW-1:0]    bus_adr,
  input  logic [SEL_W-1:0]     bus_sel,
  input  logic [BUS_DW-1:0]    bus_dat_w,
  output logic [BUS_DW-1:0]    bus_dat_r,
  output logic                 bus_ack,
  output logic                 mem_cmd_valid,
  input  logic                 mem_cmd_ready,
  output logic                 mem_cmd_we,
  output logic [NATIVE_AW-1:0] mem_cmd_addr,
  output logic                 mem_wr_valid,
  input  logic                 mem_wr_ready,
  output logic [NATIVE_DW-1:0] mem_wr_data,
  output logic [NBYTES-1:0]    mem_wr_be,
  input  logic                 mem_rd_valid,
  input  logic [NATIVE_DW-1:0] mem_rd_data
);
  // reset: asserted at once, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                 accept, rd_take;
  logic                 we_q, we_d;
  logic [BUS_AW-1:0]    adr_q, adr_d;
  logic [SEL_W-1:0]     sel_q, sel_d;
  logic [BUS_DW-1:0]    dat_q, dat_d;
  logic [BUS_DW-1:0]    rdat_q, rdat_d;
  logic [BUS_DW-1:0]    picked;
  logic [LANE_BITS-1:0] lane;

  always_comb begin
    we_d   = accept ? bus_we    : we_q;
    adr_d  = accept ? bus_adr   : adr_q;
    sel_d  = accept ? bus_sel   : sel_q;
    dat_d  = accept ? bus_dat_w : dat_q;
    rdat_d = rd_take ? picked   : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_q   <= 1'b0;
      adr_q  <= '0;
      sel_q  <= '0;
      dat_q  <= '0;
      rdat_q <= '0;
    end else begin
      we_q   <= we_d;
      adr_q  <= adr_d;
      sel_q  <= sel_d;
      dat_q  <= dat_d;
      rdat_q <= rdat_d;
    end
  end

  assign lane         = adr_q[LANE_BITS-1:0];
  assign mem_cmd_addr = adr_q[BUS_AW-1:LANE_BITS];
  assign mem_cmd_we   = we_q;
  assign bus_dat_r    = rdat_q;

  wbn_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (bus_cyc && bus_stb),
    .is_write  (we_q),
    .cmd_ready (mem_cmd_ready),
    .wr_ready  (mem_wr_ready),
    .rd_valid  (mem_rd_valid),
    .accept    (accept),
    .cmd_valid (mem_cmd_valid),
    .wr_valid  (mem_wr_valid),
    .rd_take   (rd_take),
    .ack       (bus_ack)
  );

  wbn_lane_pack #(.BUS_DW(BUS_DW), .GRAN(GRAN), .NATIVE_DW(NATIVE_DW)) u_pack (
    .lane      (lane),
    .sel       (sel_q),
    .dat       (dat_q),
    .wide_data (mem_wr_data),
    .wide_be   (mem_wr_be)
  );

  wbn_lane_pick #(.BUS_DW(BUS_DW), .NATIVE_DW(NATIVE_DW)) u_pick (
    .lane      (lane),
    .wide_data (mem_rd_data),
    .word      (picked)
  );

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_cmd_valid && !mem_cmd_ready) |=> $stable(mem_cmd_addr));
  assert_be_stable_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_wr_valid && !mem_wr_ready) |=> ($stable(mem_wr_be) && $stable(mem_wr_data)));
  assert_be_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_valid |-> (mem_wr_be != '0));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!bus_ack && !mem_cmd_valid && !mem_wr_valid));
endmodule

// File: tb/wbn_bridge_tb.sv
module wbn_bridge_tb;
  localparam int DW   = 32;
  localparam int GR   = 16;
  localparam int NDW  = 128;
  localparam int NAW  = 3;
  localparam int LN   = NDW / DW;
  localparam int LB   = $clog2(LN);
  localparam int AW   = NAW + LB;
  localparam int SW   = DW / GR;
  localparam int NB   = NDW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [AW-1:0] bus_adr = '0;
  logic [SW-1:0] bus_sel = '0;
  logic [DW-1:0] bus_dat_w = '0;
  logic [DW-1:0] bus_dat_r;
  logic bus_ack, mem_cmd_valid, mem_cmd_we, mem_wr_valid;
  logic mem_cmd_ready = 0, mem_wr_ready = 0, mem_rd_valid = 0;
  logic [NAW-1:0] mem_cmd_addr;
  logic [NDW-1:0] mem_wr_data;
  logic [NB-1:0]  mem_wr_be;
  logic [NDW-1:0] mem_rd_data = '0;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  wbn_bridge #(.BUS_DW(DW), .GRAN(GR), .NATIVE_DW(NDW), .NATIVE_AW(NAW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_sel(bus_sel), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .bus_ack(bus_ack),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_addr(mem_cmd_addr), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [NDW-1:0] act,
                       input logic [NDW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_be(input int lane, input logic [SW-1:0] sel);
    logic [NB-1:0] m = '0;
    for (int g = 0; g < SW; g++)
      if (sel == '0 || sel[g])
        for (int k = 0; k < GR/8; k++) m[lane*(DW/8) + g*(GR/8) + k] = 1'b1;
    return m;
  endfunction

  function automatic logic [NDW-1:0] exp_wd(input int lane, input logic [DW-1:0] d);
    logic [NDW-1:0] w = '0;
    w[lane*DW +: DW] = d;
    return w;
  endfunction

  task automatic access(input bit we, input logic [AW-1:0] adr, input logic [SW-1:0] sel,
                        input logic [DW-1:0] d, input int bias);
    int lane = int'(adr[LB-1:0]);
    bit cmd_done = 0, exp_ack = 0, fin = 0;
    logic [DW-1:0] exp_rd = '0;
    int guard = 0;
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = adr; bus_sel = sel; bus_dat_w = d;
    while (!fin) begin
      @(negedge clk);
      guard++;
      check(bus_ack == exp_ack, we ? "R7 ack timing" : "R8 ack timing", NDW'(bus_ack), NDW'(exp_ack));
      mem_cmd_ready = 0; mem_wr_ready = 0; mem_rd_valid = 0;
      if (bus_ack || guard > 300) begin
        if (guard > 300) check(0, "R9 access hung", 0, 1);
        if (!we) check(bus_dat_r == exp_rd, "R8 read lane", NDW'(bus_dat_r), NDW'(exp_rd));
        bus_cyc = 0; bus_stb = 0;
        @(negedge clk);
        check(!bus_ack, "R9 ack one cycle", NDW'(bus_ack), 0);
        check(!mem_cmd_valid, "R9 no new command", NDW'(mem_cmd_valid), 0);
        fin = 1;
      end else if (exp_ack) begin
        // ack was due and missing: already reported
      end else if (!cmd_done) begin
        check(mem_cmd_valid, "R3 cmd held", NDW'(mem_cmd_valid), 1);
        check(!mem_wr_valid, "R9 exclusive", NDW'(mem_wr_valid), 0);
        check(mem_cmd_addr == adr[AW-1:LB], "R2 cmd addr", NDW'(mem_cmd_addr), NDW'(adr[AW-1:LB]));
        check(mem_cmd_we == we, "R2 cmd we", NDW'(mem_cmd_we), NDW'(we));
        if (($urandom % 100) < bias) begin mem_cmd_ready = 1; cmd_done = 1; end
      end else if (we) begin
        check(mem_wr_valid, "R7 wr valid", NDW'(mem_wr_valid), 1);
        check(mem_wr_data == exp_wd(lane, d), "R4 wr data", mem_wr_data, exp_wd(lane, d));
        check(mem_wr_be == exp_be(lane, sel), sel == '0 ? "R6 zero sel be" : "R5 be",
              NDW'(mem_wr_be), NDW'(exp_be(lane, sel)));
        if (($urandom % 100) < bias) begin mem_wr_ready = 1; exp_ack = 1; end
      end else begin
        mem_rd_data = {$urandom, $urandom, $urandom, $urandom};
        if (($urandom % 100) < bias) begin
          mem_rd_valid = 1; exp_ack = 1; exp_rd = mem_rd_data[lane*DW +: DW];
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!bus_ack && !mem_cmd_valid && !mem_wr_valid, "R1 in reset",
          NDW'({bus_ack, mem_cmd_valid, mem_wr_valid}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!bus_ack && !mem_cmd_valid && !mem_wr_valid, "R1 after reset",
          NDW'({bus_ack, mem_cmd_valid, mem_wr_valid}), 0);
    // directed: mask corners (16-bit granularity, lanes 0..3)
    access(1, {3'd1, 2'd2}, 2'b01, 32'hBAD0DAB0, 100);
    access(1, {3'd5, 2'd3}, 2'b11, 32'hFEEDFACE, 100);
    access(1, {3'd0, 2'd0}, 2'b00, 32'hBEEFCAFE, 100);
    access(1, {3'd7, 2'd1}, 2'b10, 32'h12345678, 100);
    for (int l = 0; l < LN; l++) access(0, AW'(l), 2'b11, '0, 100);
    access(1, {3'd2, 2'd1}, 2'b00, 32'hA5A5A5A5, 20);
    access(0, {3'd6, 2'd2}, 2'b00, '0, 20);
    // random
    for (int i = 0; i < 200; i++)
      access($urandom % 2, AW'($urandom), SW'($urandom), $urandom, 30 + ($urandom % 70));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule